// File: doc/BRIEF.md
# External Clock Bypass Request Controller

This block decides when the chip's clocks should move over to an externally supplied source. It handles the request/acknowledge exchange with an analog clock generator and tells the downstream clock dividers when to undo one divide step. Two separate paths can raise the bypass request. The first is a software select register, which only counts while a debug-enable control input is On. The second is a direct bypass-request control input.

All control inputs use a 4-bit redundant two-state code. A lock register can freeze the select register. Software can clear the lock but cannot set it again, so once cleared the select value holds until the next reset.

The acknowledge from the clock source comes from another timing domain. It crosses a two-flop synchronizer before it is used. Once the synchronized acknowledge is On, a step-down control is raised to the dividers, unless scan mode is On.

Top module: `xclk_byp_ctrl`

## Requirements
- R1: During and after reset, `src_req_o` is Off, `step_down_o` is 0, `sel_rdata_o` is Off and `lock_rdata_o` is 1.
- R2: The On code is 4'b1010 and the Off code is 4'b0101. Any input value other than exactly 4'b1010 is treated as Off.
- R3: When the select register holds On and `dbg_en_i` is On, `src_req_o` is On from the next clock edge.
- R4: When `byp_req_i` is On, `src_req_o` is On from the next clock edge, whatever the select register holds.
- R5: When neither request path is active, `src_req_o` is Off from the next clock edge. `src_req_o` only ever carries the On or the Off code.
- R6: Writing 0 to the lock register clears it, and writing 1 has no effect. Once cleared, the lock reads 0 until reset.
- R7: A write to the select register takes effect at the next edge only while the lock reads 1. With the lock at 0, the write is ignored. A select write and a lock clear in the same cycle use the lock value from before that edge.
- R8: A select value of On raises no request while `dbg_en_i` is not On.
- R9: `src_ack_i` passes through two synchronizer flops and one output register. An acknowledge that is On before edge k makes `step_down_o` 1 after edge k+2, provided scan mode is not On.
- R10: While `scan_mode_i` is On, `step_down_o` is 0 from the next edge.
- R11: When the acknowledge goes Off before edge k, `step_down_o` is 0 after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_wr_i | input | 1 | Write strobe for the select register |
| sel_wdata_i | input | 4 | Select write data |
| lock_wr_i | input | 1 | Write strobe for the lock register |
| lock_wdata_i | input | 1 | Lock write data (0 clears) |
| sel_rdata_o | output | 4 | Select register contents |
| lock_rdata_o | output | 1 | Lock register contents |
| dbg_en_i | input | 4 | Debug-enable control, redundant code |
| byp_req_i | input | 4 | Direct bypass request, redundant code |
| scan_mode_i | input | 4 | Scan-mode control, redundant code |
| src_req_o | output | 4 | Bypass request to the clock source |
| src_ack_i | input | 4 | Acknowledge from the clock source |
| step_down_o | output | 1 | Divider step-down control |

## Verification
The assertions check on every cycle the following:
- each request path forces `src_req_o` to On one edge later;
- with neither path active, the request falls;
- the request only ever carries a legal code;
- a cleared lock never comes back and keeps the select register frozen;
- scan mode holds the step-down low, and step-down never rises while scan mode is On.

The exact synchronizer latency for both edges of the acknowledge needs the bench's scenarios, since it is a three-edge window. So do the rejection of near-miss codes, the same-cycle select write with lock clear, and the lock's return to 1 after reset.

// File: rtl/xclk_byp_pkg.sv
package xclk_byp_pkg;
    localparam int TX_W = 4;
    localparam logic [TX_W-1:0] TX_ON  = {(TX_W/2){2'b10}};
    localparam logic [TX_W-1:0] TX_OFF = {(TX_W/2){2'b01}};

    function automatic logic tx_is_on(input logic [TX_W-1:0] v);
        return v == TX_ON;
    endfunction

    typedef struct packed {
        logic [TX_W-1:0] sel;
        logic            lock;
    } regs_t;

    typedef struct packed {
        logic [TX_W-1:0] req;
        logic            step;
    } ctl_t;
endpackage

// File: rtl/xclk_byp_regs.sv
module xclk_byp_regs
    import xclk_byp_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sel_wr_i,
    input  logic [TX_W-1:0] sel_wdata_i,
    input  logic            lock_wr_i,
    input  logic            lock_wdata_i,
    output logic [TX_W-1:0] sel_o,
    output logic            lock_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // select write is gated by the lock value held before this edge
        if (sel_wr_i && r_q.lock) begin
            r_d.sel = sel_wdata_i;
        end
        // lock can only be cleared
        if (lock_wr_i && !lock_wdata_i) begin
            r_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.sel  <= TX_OFF;
            r_q.lock <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o  = r_q.sel;
    assign lock_o = r_q.lock;
endmodule

// File: rtl/xclk_byp_sync.sv
module xclk_byp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/xclk_byp_ctrl.sv
module xclk_byp_ctrl
    import xclk_byp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sel_wr_i,
    input  logic [TX_W-1:0] sel_wdata_i,
    input  logic            lock_wr_i,
    input  logic            lock_wdata_i,
    output logic [TX_W-1:0] sel_rdata_o,
    output logic            lock_rdata_o,
    input  logic [TX_W-1:0] dbg_en_i,
    input  logic [TX_W-1:0] byp_req_i,
    input  logic [TX_W-1:0] scan_mode_i,
    output logic [TX_W-1:0] src_req_o,
    input  logic [TX_W-1:0] src_ack_i,
    output logic            step_down_o
);
    logic [TX_W-1:0] sel_q;
    logic            lock_q;
    logic [TX_W-1:0] ack_sync;
    ctl_t            c_d, c_q;

    xclk_byp_regs u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sel_wr_i     (sel_wr_i),
        .sel_wdata_i  (sel_wdata_i),
        .lock_wr_i    (lock_wr_i),
        .lock_wdata_i (lock_wdata_i),
        .sel_o        (sel_q),
        .lock_o       (lock_q)
    );

    xclk_byp_sync #(
        .W       (TX_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (TX_OFF)
    ) u_ack_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (src_ack_i),
        .q_o    (ack_sync)
    );

    always_comb begin
        logic sw_path, hw_path;
        sw_path  = tx_is_on(sel_q) && tx_is_on(dbg_en_i);
        hw_path  = tx_is_on(byp_req_i);
        c_d.req  = (sw_path || hw_path) ? TX_ON : TX_OFF;
        c_d.step = tx_is_on(ack_sync) && !tx_is_on(scan_mode_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.req  <= TX_OFF;
            c_q.step <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign src_req_o    = c_q.req;
    assign step_down_o  = c_q.step;
    assign sel_rdata_o  = sel_q;
    assign lock_rdata_o = lock_q;
endmodule

// File: rtl/xclk_byp_ctrl_chk.sv
module xclk_byp_ctrl_chk
    import xclk_byp_pkg::*;
(
    input logic            clk_i,
    input logic            rst_ni,
    input logic [TX_W-1:0] sel_rdata_o,
    input logic            lock_rdata_o,
    input logic [TX_W-1:0] dbg_en_i,
    input logic [TX_W-1:0] byp_req_i,
    input logic [TX_W-1:0] scan_mode_i,
    input logic [TX_W-1:0] src_req_o,
    input logic            step_down_o
);
    // R3
    sw_path_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_rdata_o == TX_ON && dbg_en_i == TX_ON) |=> (src_req_o == TX_ON));

    // R4
    hw_path_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byp_req_i == TX_ON) |=> (src_req_o == TX_ON));

    // R5
    req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byp_req_i != TX_ON && !(sel_rdata_o == TX_ON && dbg_en_i == TX_ON))
        |=> (src_req_o == TX_OFF));

    // R5
    req_legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_req_o == TX_ON) || (src_req_o == TX_OFF));

    // R6
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_rdata_o |=> !lock_rdata_o);

    // R7
    sel_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_rdata_o |=> $stable(sel_rdata_o));

    // R10
    scan_blocks_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_mode_i == TX_ON) |=> !step_down_o);

    // R10
    step_rise_no_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(step_down_o) |-> ($past(scan_mode_i) != TX_ON));
endmodule

bind xclk_byp_ctrl xclk_byp_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_rdata_o  (sel_rdata_o),
    .lock_rdata_o (lock_rdata_o),
    .dbg_en_i     (dbg_en_i),
    .byp_req_i    (byp_req_i),
    .scan_mode_i  (scan_mode_i),
    .src_req_o    (src_req_o),
    .step_down_o  (step_down_o)
);

// File: tb/xclk_byp_ctrl_tb.sv
module xclk_byp_ctrl_tb;
    localparam logic [3:0] ON  = 4'b1010;
    localparam logic [3:0] OFF = 4'b0101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [3:0] sel_wdata = OFF;
    logic       lock_wr = 1'b0;
    logic       lock_wdata = 1'b1;
    logic [3:0] sel_rdata;
    logic       lock_rdata;
    logic [3:0] dbg_en = OFF;
    logic [3:0] byp_req = OFF;
    logic [3:0] scan_mode = OFF;
    logic [3:0] src_req;
    logic [3:0] src_ack = OFF;
    logic       step_down;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    xclk_byp_ctrl u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sel_wr_i     (sel_wr),
        .sel_wdata_i  (sel_wdata),
        .lock_wr_i    (lock_wr),
        .lock_wdata_i (lock_wdata),
        .sel_rdata_o  (sel_rdata),
        .lock_rdata_o (lock_rdata),
        .dbg_en_i     (dbg_en),
        .byp_req_i    (byp_req),
        .scan_mode_i  (scan_mode),
        .src_req_o    (src_req),
        .src_ack_i    (src_ack),
        .step_down_o  (step_down)
    );

    // behavioural reference model
    int m_sel;
    bit m_lock;
    bit m_req;
    bit m_step;
    bit m_ack_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel  = int'(OFF);
            m_lock = 1;
            m_req  = 0;
            m_step = 0;
            m_ack_q = {0, 0};
        end else begin
            m_req  = (m_sel == int'(ON) && dbg_en == ON) || (byp_req == ON);
            m_step = m_ack_q[0] && (scan_mode != ON);
            void'(m_ack_q.pop_front());
            m_ack_q.push_back(src_ack == ON);
            if (sel_wr && m_lock) m_sel = int'(sel_wdata);
            if (lock_wr && lock_wdata == 1'b0) m_lock = 0;
        end
    end

    task automatic cmp(string t, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        cmp(tag, int'(src_req), m_req ? int'(ON) : int'(OFF), "src_req_o");
        cmp(tag, int'(step_down), int'(m_step), "step_down_o");
        cmp("R7", int'(sel_rdata), m_sel, "sel_rdata_o");
        cmp("R6", int'(lock_rdata), int'(m_lock), "lock_rdata_o");
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        wait (cycles > 5000);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_sel(logic [3:0] v);
        sel_wr = 1'b1;
        sel_wdata = v;
        idle(1);
        sel_wr = 1'b0;
    endtask

    task automatic wr_lock(logic v);
        lock_wr = 1'b1;
        lock_wdata = v;
        idle(1);
        lock_wr = 1'b0;
    endtask

    initial begin
        tag = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R3: software path
        tag = "R3";
        dbg_en = ON;
        wr_sel(ON);
        idle(3);

        // R8: select On, debug not On
        tag = "R8";
        dbg_en = OFF;
        idle(3);

        // R2: near-miss code is Off
        tag = "R2";
        dbg_en = 4'b1011;
        idle(3);
        byp_req = 4'b1110;
        idle(3);

        // R4: hardware path with select Off
        tag = "R4";
        dbg_en = OFF;
        wr_sel(OFF);
        byp_req = ON;
        idle(3);

        // R5: both paths gone
        tag = "R5";
        byp_req = OFF;
        idle(3);

        // R9: acknowledge latency
        tag = "R9";
        src_ack = ON;
        idle(5);

        // R10: scan mode suppresses, near-miss scan code does not
        tag = "R10";
        scan_mode = ON;
        idle(3);
        scan_mode = 4'b0010;
        idle(3);
        scan_mode = OFF;
        idle(1);

        // R11: acknowledge drop
        tag = "R11";
        src_ack = OFF;
        idle(5);

        // R6: writing 1 does nothing; writing 0 clears
        tag = "R6";
        wr_lock(1'b1);
        idle(2);
        // R7: same-cycle select write and lock clear uses old lock
        tag = "R7";
        dbg_en = ON;
        sel_wr = 1'b1;
        sel_wdata = ON;
        lock_wr = 1'b1;
        lock_wdata = 1'b0;
        idle(1);
        sel_wr = 1'b0;
        lock_wr = 1'b0;
        idle(3);
        // R7: writes ignored when locked
        wr_sel(OFF);
        idle(3);
        wr_lock(1'b1);
        idle(2);

        // R1/R6: reset restores lock and select
        tag = "R1";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        dbg_en = OFF;
        idle(2);
        tag = "R6";
        wr_sel(ON);
        dbg_en = ON;
        idle(3);

        finish_run();
    end
endmodule